// File: doc/BRIEF.md
# Interrupt Pin Router to Message-Signalled Writes

This block collects interrupt requests from up to 24 input pins and turns each one it may deliver into a single address/data write toward an interrupt controller. Each pin has a 64-bit redirection entry, loaded through a simple write port. The entry holds the vector, delivery mode, destination, destination mode, trigger mode and mask. Requests arrive as events. Each event names a source number and a level. Source 0 is steered onto pin 2, and source numbers beyond the last pin are dropped.

Edge pins latch a pending bit on a request, and the bit clears once the message is issued. Level pins follow the input: the pending bit is set while the input is high and clears when it falls. A delivered level pin raises an in-service flag, and no further messages are sent for that pin until the flag is cleared. Only a reprogramming write that selects edge trigger clears the flag; end-of-interrupt handling sits outside this block. The in-service flags are brought out as a vector. Messages leave through a valid/ready handshake, one at a time, with the lowest-numbered eligible pin going first.

Top module: `irq_msi_router`

## Requirements
- R1: After reset no message is valid, every in-service flag is clear and every entry is masked with edge trigger, so a request made before any entry is written produces no message.
- R2: An edge request (event with level 1) on an unmasked edge pin produces exactly one message and then clears that pin's pending state. An event with level 0 on an edge pin has no effect.
- R3: An edge request on a masked pin is discarded; unmasking that pin later produces no message.
- R4: A level pin whose input goes high while unmasked produces one message and sets its in-service flag. While that flag stays set, further level activity on the pin produces no message.
- R5: Dropping a level input clears its pending state, so unmasking the pin afterwards produces no message.
- R6: A pending level request on a masked pin is retained and is delivered once the pin is unmasked.
- R7: Source 0 acts on pin 2. Sources at or above the pin count are discarded.
- R8: Message address = 0xFEE00000 with destination (entry bits 63:48) in address bits 19:4 and destination mode (entry bit 11) in address bit 2. Message data holds the vector (entry bits 7:0) in 7:0, the delivery mode (entry bits 10:8) in 10:8 and the trigger mode (entry bit 15, 1 = level) in bit 15. Entry bit 16 is the mask.
- R9: At most one message is outstanding. The address and data hold steady while ready is low. After each handshake valid drops for at least one cycle. The lowest-numbered eligible pin is sent next.
- R10: A write to an entry keeps that pin's in-service flag when the new entry selects level trigger, and clears it when the new entry selects edge trigger. A level pin still held high is then delivered again once it is programmed back to level and unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Request event strobe |
| evt_src | input | SRC_W | Source number of the event |
| evt_level | input | 1 | Input level carried by the event |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | PIN_W | Pin whose entry is written |
| cfg_data | input | 64 | New entry value |
| msi_valid | output | 1 | Message valid |
| msi_ready | input | 1 | Message accepted by the receiver |
| msi_addr | output | 32 | Message address |
| msi_data | output | 32 | Message data |
| remote_irr | output | NUM_PINS | In-service flag per pin |

## Verification
The checks assume the receiver follows the handshake. Ready may be held low for any length of time, and it has no effect while valid is low. The assertions also rely on the in-service flags being raised only by a delivery, never by a write. The bench holds ready high except in the one test that stalls the output. Its entry writes never set bit 14, and each event lasts one cycle.

// File: rtl/irq_msi_router.sv
module irq_msi_router #(
  parameter int          NUM_PINS = 24,
  parameter int          SRC_W    = 6,
  parameter logic [31:0] MSI_BASE = 32'hFEE0_0000,
  localparam int         PIN_W    = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_valid,
  input  logic [SRC_W-1:0]    evt_src,
  input  logic                evt_level,
  input  logic                cfg_we,
  input  logic [PIN_W-1:0]    cfg_idx,
  input  logic [63:0]         cfg_data,
  output logic                msi_valid,
  input  logic                msi_ready,
  output logic [31:0]         msi_addr,
  output logic [31:0]         msi_data,
  output logic [NUM_PINS-1:0] remote_irr
);

  logic [7:0]          vec_q   [NUM_PINS];
  logic [2:0]          dlv_q   [NUM_PINS];
  logic [15:0]         dest_q  [NUM_PINS];
  logic [NUM_PINS-1:0] dmode_q, lvl_q, mask_q, irr_q, rirr_q;
  logic [NUM_PINS-1:0] irr_d, rirr_d, elig;
  logic [PIN_W-1:0]    sel, evt_pin;
  logic [SRC_W-1:0]    src_map;
  logic                evt_hit, cfg_ok, load;
  logic                cfg_unused;

  assign cfg_unused = ^{cfg_data[47:17], cfg_data[14:12]};

  assign src_map = (evt_src == '0) ? SRC_W'(2) : evt_src;
  assign evt_hit = evt_valid && (src_map < SRC_W'(NUM_PINS));
  assign evt_pin = src_map[PIN_W-1:0];
  assign cfg_ok  = cfg_we && (cfg_idx < PIN_W'(NUM_PINS));

  assign elig = irr_q & ~mask_q & ~(lvl_q & rirr_q);
  assign load = !msi_valid && (|elig);

  always_comb begin
    sel = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--)
      if (elig[i]) sel = PIN_W'(i);
  end

  always_comb begin
    irr_d = irr_q;
    if (load && !lvl_q[sel]) irr_d[sel] = 1'b0;
    if (evt_hit) begin
      if (lvl_q[evt_pin])
        irr_d[evt_pin] = evt_level;
      else if (evt_level && !mask_q[evt_pin])
        irr_d[evt_pin] = 1'b1;
    end
  end

  always_comb begin
    rirr_d = rirr_q;
    if (load && lvl_q[sel]) rirr_d[sel] = 1'b1;
    if (cfg_ok && !cfg_data[15]) rirr_d[cfg_idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q   <= '0;
      rirr_q  <= '0;
      mask_q  <= '1;
      lvl_q   <= '0;
      dmode_q <= '0;
      for (int i = 0; i < NUM_PINS; i++) begin
        vec_q[i]  <= '0;
        dlv_q[i]  <= '0;
        dest_q[i] <= '0;
      end
    end else begin
      irr_q  <= irr_d;
      rirr_q <= rirr_d;
      if (cfg_ok) begin
        vec_q[cfg_idx]   <= cfg_data[7:0];
        dlv_q[cfg_idx]   <= cfg_data[10:8];
        dmode_q[cfg_idx] <= cfg_data[11];
        lvl_q[cfg_idx]   <= cfg_data[15];
        mask_q[cfg_idx]  <= cfg_data[16];
        dest_q[cfg_idx]  <= cfg_data[63:48];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msi_valid <= 1'b0;
      msi_addr  <= '0;
      msi_data  <= '0;
    end else if (load) begin
      msi_valid <= 1'b1;
      msi_addr  <= MSI_BASE | {12'h0, dest_q[sel], 1'b0, dmode_q[sel], 2'b00};
      msi_data  <= {16'h0, lvl_q[sel], 4'h0, dlv_q[sel], vec_q[sel]};
    end else if (msi_ready) begin
      msi_valid <= 1'b0;
    end
  end

  assign remote_irr = rirr_q;

endmodule

module irq_msi_router_chk #(
  parameter int NUM_PINS = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                msi_valid,
  input logic                msi_ready,
  input logic [31:0]         msi_addr,
  input logic [31:0]         msi_data,
  input logic [NUM_PINS-1:0] remote_irr
);

  // R9
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_valid && !msi_ready |=> msi_valid && $stable(msi_addr) && $stable(msi_data));

  // R9
  gap_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_valid && msi_ready |=> !msi_valid);

  // R8
  addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_valid |-> msi_addr[31:20] == 12'hFEE && msi_addr[3] == 1'b0 && msi_addr[1:0] == 2'b00);

  // R4
  flag_needs_message_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(remote_irr & ~$past(remote_irr))) |-> $rose(msi_valid) && msi_data[15]);

  // R9
  one_flag_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(remote_irr & ~$past(remote_irr)) <= 1);

endmodule

bind irq_msi_router irq_msi_router_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_ready(msi_ready),
  .msi_addr(msi_addr), .msi_data(msi_data), .remote_irr(remote_irr)
);

// File: tb/irq_msi_router_tb.sv
module irq_msi_router_tb;
  localparam int NP = 24;
  localparam int SW = 6;
  localparam int PW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_valid = 1'b0, evt_level = 1'b0, cfg_we = 1'b0, msi_ready = 1'b1;
  logic [SW-1:0] evt_src = '0;
  logic [PW-1:0] cfg_idx = '0;
  logic [63:0] cfg_data = '0;
  logic msi_valid;
  logic [31:0] msi_addr, msi_data;
  logic [NP-1:0] remote_irr;

  int checks = 0, failures = 0, cap_n = 0, base;
  logic [31:0] cap_addr [64];
  logic [31:0] cap_data [64];

  always #10 clk = ~clk;

  irq_msi_router u_dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_src(evt_src),
    .evt_level(evt_level), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .msi_valid(msi_valid), .msi_ready(msi_ready), .msi_addr(msi_addr),
    .msi_data(msi_data), .remote_irr(remote_irr)
  );

  always @(negedge clk)
    if (rst_n && msi_valid && msi_ready && cap_n < 64) begin
      cap_addr[cap_n] = msi_addr;
      cap_data[cap_n] = msi_data;
      cap_n++;
    end

  // columns: source, entry, expected address, expected data
  localparam logic [133:0] TBL [4] = '{
    {6'd5,  64'h0003_0000_0000_0031, 32'hFEE0_0030, 32'h0000_0031},
    {6'd23, 64'h00FF_0000_0000_09A7, 32'hFEE0_0FF4, 32'h0000_01A7},
    {6'd1,  64'hABCD_0000_0000_0440, 32'hFEEA_BCD0, 32'h0000_0440},
    {6'd10, 64'h1234_0000_0000_2FFF, 32'hFEE1_2344, 32'h0000_07FF}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int pin, input logic [63:0] v);
    @(posedge clk); #2 cfg_we = 1'b1; cfg_idx = PW'(pin); cfg_data = v;
    @(posedge clk); #2 cfg_we = 1'b0;
  endtask

  task automatic ev(input int src, input logic lvl);
    @(posedge clk); #2 evt_valid = 1'b1; evt_src = SW'(src); evt_level = lvl;
    @(posedge clk); #2 evt_valid = 1'b0;
  endtask

  task automatic idle();
    repeat (8) @(posedge clk);
  endtask

  initial begin
    #2000000;
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(!msi_valid, "R1 valid after reset", msi_valid, 0);
    chk(remote_irr == '0, "R1 flags after reset", remote_irr, 0);

    base = cap_n;
    ev(3, 1'b1); idle();
    wr(3, 64'h0000_0000_0000_0033); idle();
    chk(cap_n == base, "R1 default mask", cap_n - base, 0);

    for (int i = 0; i < 4; i++) begin
      base = cap_n;
      wr(int'(TBL[i][133:128]), TBL[i][127:64]);
      ev(int'(TBL[i][133:128]), 1'b1); idle();
      chk(cap_n == base + 1, "R2 one message", cap_n - base, 1);
      chk(cap_addr[base] == TBL[i][63:32], "R8 address", cap_addr[base], TBL[i][63:32]);
      chk(cap_data[base] == TBL[i][31:0], "R8 data", cap_data[base], TBL[i][31:0]);
    end
    base = cap_n;
    ev(5, 1'b0); idle();
    chk(cap_n == base, "R2 low event on edge pin", cap_n - base, 0);

    base = cap_n;
    wr(6, 64'h0000_0000_0001_0022); ev(6, 1'b1); idle();
    wr(6, 64'h0000_0000_0000_0022); idle();
    chk(cap_n == base, "R3 masked edge dropped", cap_n - base, 0);

    base = cap_n;
    wr(8, 64'h0002_0000_0000_8055); ev(8, 1'b1); idle();
    chk(cap_n == base + 1, "R4 level delivered", cap_n - base, 1);
    chk(cap_data[base] == 32'h8055, "R4 level data", cap_data[base], 32'h8055);
    chk(cap_addr[base] == 32'hFEE0_0020, "R8 level address", cap_addr[base], 32'hFEE0_0020);
    chk(remote_irr == NP'(1 << 8), "R4 flag set", remote_irr, NP'(1 << 8));
    ev(8, 1'b0); ev(8, 1'b1); idle();
    chk(cap_n == base + 1, "R4 suppressed while in service", cap_n - base, 1);
    wr(8, 64'h0002_0000_0000_8056); idle();
    chk(remote_irr[8], "R10 level write keeps flag", remote_irr[8], 1);
    chk(cap_n == base + 1, "R10 no message on level rewrite", cap_n - base, 1);
    wr(8, 64'h0000_0000_0001_0055); idle();
    chk(!remote_irr[8], "R10 edge write clears flag", remote_irr[8], 0);
    wr(8, 64'h0002_0000_0000_8055); idle();
    chk(cap_n == base + 2, "R10 redelivery", cap_n - base, 2);
    chk(remote_irr[8], "R10 flag set again", remote_irr[8], 1);
    ev(8, 1'b0);
    wr(8, 64'h0000_0000_0001_0055); wr(8, 64'h0002_0000_0000_8055); idle();
    chk(cap_n == base + 2, "R5 dropped level not redelivered", cap_n - base, 2);

    base = cap_n;
    wr(12, 64'h0000_0000_0001_8012); ev(12, 1'b1); idle();
    chk(cap_n == base, "R6 masked level held", cap_n - base, 0);
    wr(12, 64'h0000_0000_0000_8012); idle();
    chk(cap_n == base + 1, "R6 delivered on unmask", cap_n - base, 1);
    chk(cap_data[base] == 32'h8012, "R6 data", cap_data[base], 32'h8012);

    base = cap_n;
    wr(13, 64'h0000_0000_0001_8013); ev(13, 1'b1); ev(13, 1'b0);
    wr(13, 64'h0000_0000_0000_8013); idle();
    chk(cap_n == base, "R5 cleared before unmask", cap_n - base, 0);

    base = cap_n;
    wr(0, 64'h0000_0000_0000_0070); wr(2, 64'h0000_0000_0000_0062);
    ev(0, 1'b1); idle();
    chk(cap_n == base + 1, "R7 source 0 count", cap_n - base, 1);
    chk(cap_data[base] == 32'h62, "R7 source 0 to pin 2", cap_data[base], 32'h62);
    ev(26, 1'b1); ev(63, 1'b1); idle();
    chk(cap_n == base + 1, "R7 out of range dropped", cap_n - base, 1);

    base = cap_n;
    wr(20, 64'h0000_0000_0000_0020); wr(4, 64'h0000_0000_0000_0044);
    wr(9, 64'h0000_0000_0000_0099);
    @(posedge clk); #2 msi_ready = 1'b0;
    ev(20, 1'b1); ev(9, 1'b1); ev(4, 1'b1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(msi_valid && msi_data == 32'h20, "R9 held while stalled", msi_data, 32'h20);
    end
    @(posedge clk); #2 msi_ready = 1'b1;
    idle();
    chk(cap_n == base + 3, "R9 count", cap_n - base, 3);
    chk(cap_data[base] == 32'h20, "R9 first", cap_data[base], 32'h20);
    chk(cap_data[base + 1] == 32'h44, "R9 lowest pin next", cap_data[base + 1], 32'h44);
    chk(cap_data[base + 2] == 32'h99, "R9 last", cap_data[base + 2], 32'h99);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule